// File: doc/BRIEF.md
# Centre-spread modulation profile generator

This block runs on the reference clock and produces a signed frequency-offset word for a downstream fractional divider or digitally controlled oscillator. The word traces a triangle that is centred on the nominal frequency. Each modulation period it climbs to a positive peak, falls to an equal negative peak and climbs back to zero. The period is a fixed number of reference cycles. It does not depend on the setting chosen.

Two three-level select inputs together pick one of nine spread settings. Each select arrives as a 2-bit code. A 3-bit band input names the input-frequency sub-range: bit 2 chooses the lower or the upper half of the frequency range, and bits 1:0 choose one of four sub-bands inside it. The total spread comes from a table held in tenths of a percent. The peak offset is half of that spread, expressed in parts per 10000 of the nominal frequency. An enable input forces the output to zero while it is low, and the sweep keeps running underneath. A select or band change is taken only at the period boundary, where the sweep sits at zero, so the output never jumps. A select code or a band that has no table entry raises an error flag and flattens the output for that whole period.

The offset is a level that is valid in every cycle, with no handshake. The consumer samples it whenever it likes, and there is no back-pressure. The select, band, enable and error pins are plain control and status.

Top module: `ssc_profile_gen`

## Requirements
- R1: While reset is asserted and right after it, `offset_o` is 0 and `err_o` is 0. The first period after reset uses the middle/middle setting on sub-band 0 of the lower range, which gives a peak of 215.
- R2: Each select code means 2'b00 low, 2'b01 middle, 2'b10 high; 2'b11 is invalid. The settings are written {sel_x_i, sel_y_i} and give tenths of a percent for sub-bands 0..3:
  - Lower range (band_i[2]=0): MM 43/39/37/34, M-low 38/35/33/31, high-low 34/31/28/26, low-low 29/25/24/22, low-M 28/24/23/21.
  - Upper range (band_i[2]=1): high-M 29/28/26/24, M-high 21/20/18/17, high-high 15/14/13/12, low-high 12/11/11/10.
  - The peak is 5 times the table value.
- R3: Over every modulation period with a valid setting, the largest output equals +peak and the smallest equals -peak.
- R4: The period is PERIOD cycles. With HALF=PERIOD/2, K0=(HALF+1)/2 and UP1=HALF-K0, the state n cycles after a boundary (0 ≤ n < PERIOD) is:
  - for n ≤ UP1: -P + floor(2P(n+K0)/HALF);
  - for UP1 < n ≤ UP1+HALF: P - floor(2P(n-UP1)/HALF);
  - otherwise: -P + floor(2P(n-UP1-HALF)/HALF).
  - The output moves by at most 1 per cycle.
- R5: The output equals +peak exactly UP1 cycles after a boundary and -peak exactly UP1+HALF cycles after it.
- R6: While `spread_en_i` is low, `offset_o` is 0 in that same cycle. The sweep phase keeps advancing, and when the enable goes high again the output resumes at the current phase.
- R7: If either select code is 2'b11 at a boundary edge, `err_o` is 1 and `offset_o` is 0 for the whole following period.
- R8: If a setting of one range is paired with a band_i[2] of the other range at a boundary edge, `err_o` is 1 and `offset_o` is 0 for the whole following period.
- R9: Select and band values are sampled only at the clock edge that ends a period. Changes at any other time have no effect on the output until that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_x_i | input | 2 | First three-level select code |
| sel_y_i | input | 2 | Second three-level select code |
| band_i | input | 3 | Range (bit 2) and sub-band (bits 1:0) |
| spread_en_i | input | 1 | High enables the offset output |
| offset_o | output | OFF_W | Signed offset in parts per 10000 |
| err_o | output | 1 | Active setting has no table entry |

## Verification
The bench builds the block with its default parameters: a period of 1166 cycles, 10-bit offsets and 8-bit peaks. With these values every one of the nine settings runs for a full period, and the largest peak of 215 comes close to the limit at which the ramp may advance only one step per cycle. Because the half-period of 583 is odd, the start of each period falls between two integer steps, so the bench exercises the carried ramp remainder as well as the exact landing on both turning points. The run also covers a mid-period enable drop, both kinds of error, and recovery from an error.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  typedef enum logic [1:0] {
    LVL_LO  = 2'b00,
    LVL_MID = 2'b01,
    LVL_HI  = 2'b10,
    LVL_BAD = 2'b11
  } lvl_e;

  typedef struct packed {
    logic       ok;
    logic       hi_band;
    logic [5:0] tenths;
  } spread_t;

  function automatic logic [5:0] pick4(logic [1:0] s, logic [5:0] a, logic [5:0] b,
                                       logic [5:0] c, logic [5:0] d);
    case (s)
      2'd0:    return a;
      2'd1:    return b;
      2'd2:    return c;
      default: return d;
    endcase
  endfunction

  // Spread in tenths of a percent for setting {x,y} on sub-band sub.
  function automatic spread_t lookup(logic [1:0] x, logic [1:0] y, logic [1:0] sub);
    spread_t r;
    r.ok      = 1'b1;
    r.hi_band = 1'b0;
    r.tenths  = '0;
    case ({x, y})
      {LVL_MID, LVL_MID}: r.tenths = pick4(sub, 6'd43, 6'd39, 6'd37, 6'd34);
      {LVL_MID, LVL_LO }: r.tenths = pick4(sub, 6'd38, 6'd35, 6'd33, 6'd31);
      {LVL_HI,  LVL_LO }: r.tenths = pick4(sub, 6'd34, 6'd31, 6'd28, 6'd26);
      {LVL_LO,  LVL_LO }: r.tenths = pick4(sub, 6'd29, 6'd25, 6'd24, 6'd22);
      {LVL_LO,  LVL_MID}: r.tenths = pick4(sub, 6'd28, 6'd24, 6'd23, 6'd21);
      {LVL_HI,  LVL_MID}: begin r.hi_band = 1'b1; r.tenths = pick4(sub, 6'd29, 6'd28, 6'd26, 6'd24); end
      {LVL_MID, LVL_HI }: begin r.hi_band = 1'b1; r.tenths = pick4(sub, 6'd21, 6'd20, 6'd18, 6'd17); end
      {LVL_HI,  LVL_HI }: begin r.hi_band = 1'b1; r.tenths = pick4(sub, 6'd15, 6'd14, 6'd13, 6'd12); end
      {LVL_LO,  LVL_HI }: begin r.hi_band = 1'b1; r.tenths = pick4(sub, 6'd12, 6'd11, 6'd11, 6'd10); end
      default:            r.ok = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ssc_sel_decode.sv
module ssc_sel_decode
  import ssc_pkg::*;
#(
  parameter int PEAK_W = 8
) (
  input  logic [1:0]        sel_x,
  input  logic [1:0]        sel_y,
  input  logic [2:0]        band,
  output logic [PEAK_W-1:0] peak,
  output logic              bad
);

  spread_t            ent;
  logic [PEAK_W-1:0]  tenths_ext;

  always_comb begin
    ent        = lookup(sel_x, sel_y, band[1:0]);
    bad        = !ent.ok || (ent.hi_band != band[2]);
    tenths_ext = PEAK_W'(ent.tenths);
    // half of the total spread, tenths of a percent -> parts per 10000
    peak       = bad ? '0 : tenths_ext * PEAK_W'(5);
  end

  // R2: every valid table entry yields a non-zero peak
  always_comb begin
    assert_valid_nonzero_R2: assert (bad || (peak != '0));
  end

endmodule

// File: rtl/ssc_ramp.sv
module ssc_ramp #(
  parameter int                PERIOD   = 1166,
  parameter int                PEAK_W   = 8,
  parameter int                OFF_W    = 10,
  parameter logic [PEAK_W-1:0] RST_PEAK = 8'd215
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PEAK_W-1:0]       next_peak,
  output logic signed [OFF_W-1:0] off,
  output logic                    boundary
);

  localparam int HALF  = PERIOD / 2;
  localparam int K0    = (HALF + 1) / 2;
  localparam int UP1   = HALF - K0;
  localparam int DN    = UP1 + HALF;
  localparam int CNT_W = $clog2(PERIOD);
  localparam int ACC_W = $clog2(HALF) + 1;
  localparam logic signed [OFF_W-1:0] ONE = 1;

  logic [CNT_W-1:0]        cnt_q;
  logic [ACC_W-1:0]        acc_q;
  logic signed [OFF_W-1:0] off_q;
  logic [PEAK_W-1:0]       peak_q;
  logic [ACC_W:0]          sum;
  logic                    carry;
  logic                    rising;
  logic [ACC_W-1:0]        acc_load;
  logic [ACC_W-1:0]        acc_rst;
  logic signed [OFF_W-1:0] peak_s;

  // Remainder held at the period start, where the sweep crosses zero
  // between two integer ramp steps when HALF is odd.
  generate
    if (HALF % 2 == 1) begin : g_odd_half
      assign acc_load = ACC_W'(next_peak);
      assign acc_rst  = ACC_W'(RST_PEAK);
    end else begin : g_even_half
      assign acc_load = '0;
      assign acc_rst  = '0;
    end
  endgenerate

  always_comb begin
    sum      = {1'b0, acc_q} + (ACC_W+1)'({peak_q, 1'b0});
    carry    = sum >= (ACC_W+1)'(HALF);
    rising   = (cnt_q < CNT_W'(UP1)) || (cnt_q >= CNT_W'(DN));
    boundary = cnt_q == CNT_W'(PERIOD - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      acc_q  <= acc_rst;
      off_q  <= '0;
      peak_q <= RST_PEAK;
    end else if (boundary) begin
      cnt_q  <= '0;
      acc_q  <= acc_load;
      off_q  <= '0;
      peak_q <= next_peak;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
      acc_q <= carry ? ACC_W'(sum - (ACC_W+1)'(HALF)) : ACC_W'(sum);
      if (carry) off_q <= rising ? off_q + ONE : off_q - ONE;
    end
  end

  assign off    = off_q;
  assign peak_s = OFF_W'(peak_q);

  assert_within_peak_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (off_q <= peak_s) && (off_q >= -peak_s));

  assert_unit_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(off_q) == off_q) || ($past(off_q) + ONE == off_q) || ($past(off_q) == off_q + ONE));

  assert_crest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_W'(UP1)) |-> (off_q == peak_s));

  assert_trough_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_W'(DN)) |-> (off_q == -peak_s));

  assert_load_at_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(peak_q));

endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen
  import ssc_pkg::*;
#(
  parameter int PERIOD = 1166,
  parameter int OFF_W  = 10,
  parameter int PEAK_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              sel_x_i,
  input  logic [1:0]              sel_y_i,
  input  logic [2:0]              band_i,
  input  logic                    spread_en_i,
  output logic signed [OFF_W-1:0] offset_o,
  output logic                    err_o
);

  localparam spread_t           RST_SET  = lookup(LVL_MID, LVL_MID, 2'b00);
  localparam logic [PEAK_W-1:0] RST_PEAK = PEAK_W'(RST_SET.tenths) * PEAK_W'(5);

  logic [PEAK_W-1:0]       dec_peak;
  logic                    dec_bad;
  logic signed [OFF_W-1:0] ramp_off;
  logic                    boundary;
  logic                    err_q;

  ssc_sel_decode #(.PEAK_W(PEAK_W)) u_dec (
    .sel_x (sel_x_i),
    .sel_y (sel_y_i),
    .band  (band_i),
    .peak  (dec_peak),
    .bad   (dec_bad)
  );

  ssc_ramp #(
    .PERIOD   (PERIOD),
    .PEAK_W   (PEAK_W),
    .OFF_W    (OFF_W),
    .RST_PEAK (RST_PEAK)
  ) u_ramp (
    .clk       (clk),
    .rst_n     (rst_n),
    .next_peak (dec_peak),
    .off       (ramp_off),
    .boundary  (boundary)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        err_q <= 1'b0;
    else if (boundary) err_q <= dec_bad;
  end

  assign offset_o = (spread_en_i && !err_q) ? ramp_off : '0;
  assign err_o    = err_q;

  // R7 and R8: a rejected setting leaves the sweep itself flat
  assert_err_flat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (ramp_off == '0));

endmodule

// File: tb/ssc_profile_gen_tb_top.sv
`timescale 1ns/1ps
module ssc_profile_gen_tb_top;

  localparam int PERIOD = 1166;
  localparam int OFF_W  = 10;
  localparam int PEAK_W = 8;
  localparam int HALF   = PERIOD / 2;
  localparam int K0     = (HALF + 1) / 2;
  localparam int UP1    = HALF - K0;
  localparam int DN     = UP1 + HALF;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                    rst_n       = 1'b0;
  logic [1:0]              sel_x       = 2'b01;
  logic [1:0]              sel_y       = 2'b01;
  logic [2:0]              band        = 3'b000;
  logic                    spread_en   = 1'b1;
  logic signed [OFF_W-1:0] offset_o;
  logic                    err_o;

  ssc_profile_gen #(.PERIOD(PERIOD), .OFF_W(OFF_W), .PEAK_W(PEAK_W)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_x_i     (sel_x),
    .sel_y_i     (sel_y),
    .band_i      (band),
    .spread_en_i (spread_en),
    .offset_o    (offset_o),
    .err_o       (err_o)
  );

  typedef struct {
    int    off;
    bit    err;
    string tag;
    bit    sym;
    int    sym_p;
  } item_t;

  item_t q[$];
  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  string cur_tag  = "R4";
  string pend_tag = "R4";
  bit    chg = 1'b0;

  function automatic int exp_peak(input logic [1:0] x, input logic [1:0] y,
                                  input logic [2:0] b, output bit bad);
    int t[4];
    bit hi;
    bad = 1'b0;
    hi  = 1'b0;
    case ({x, y})
      4'b0101: t = '{43, 39, 37, 34};
      4'b0100: t = '{38, 35, 33, 31};
      4'b1000: t = '{34, 31, 28, 26};
      4'b0000: t = '{29, 25, 24, 22};
      4'b0001: t = '{28, 24, 23, 21};
      4'b1001: begin hi = 1'b1; t = '{29, 28, 26, 24}; end
      4'b0110: begin hi = 1'b1; t = '{21, 20, 18, 17}; end
      4'b1010: begin hi = 1'b1; t = '{15, 14, 13, 12}; end
      4'b0010: begin hi = 1'b1; t = '{12, 11, 11, 10}; end
      default: begin bad = 1'b1; t = '{0, 0, 0, 0}; end
    endcase
    if (!bad && (hi != b[2])) bad = 1'b1;
    return bad ? 0 : 5 * t[b[1:0]];
  endfunction

  function automatic int ramp_at(input int n, input int p);
    if (n <= UP1)     return -p + (2 * p * (n + K0)) / HALF;
    else if (n <= DN) return p - (2 * p * (n - UP1)) / HALF;
    else              return -p + (2 * p * (n - DN)) / HALF;
  endfunction

  task automatic wait_cyc(input int k);
    repeat (k) @(posedge clk);
    #2;
  endtask

  task automatic apply(input logic [1:0] x, input logic [1:0] y,
                       input logic [2:0] b, input string t);
    sel_x    = x;
    sel_y    = y;
    band     = b;
    pend_tag = t;
    chg      = 1'b1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Driver: model of the requirements, one expected item per cycle
  initial begin : model
    int    n;
    int    pm;
    int    prev_p;
    bit    errm;
    bit    sym;
    logic [1:0] cx, cy;
    logic [2:0] cb;
    item_t it;
    n    = 0;
    pm   = 215;
    errm = 1'b0;
    @(posedge rst_n);
    #1;
    it = '{off: ramp_at(0, pm), err: 1'b0, tag: "R1", sym: 1'b0, sym_p: 0};
    q.push_back(it);
    forever begin
      @(posedge clk);
      cx = sel_x; cy = sel_y; cb = band;
      #3;
      sym    = 1'b0;
      prev_p = pm;
      if (n == PERIOD - 1) begin
        n       = 0;
        pm      = exp_peak(cx, cy, cb, errm);
        sym     = 1'b1;
        cur_tag = pend_tag;
        chg     = 1'b0;
      end else begin
        n++;
      end
      it.tag = cur_tag;
      if (n == UP1 || n == DN) it.tag = "R5";
      if (chg)        it.tag = "R9";
      if (!spread_en) it.tag = "R6";
      it.off   = (spread_en && !errm) ? ramp_at(n, pm) : 0;
      it.err   = errm;
      it.sym   = sym;
      it.sym_p = prev_p;
      q.push_back(it);
    end
  end

  // Monitor: pops expected items and compares at the falling edge
  initial begin : monitor
    item_t it;
    int    got;
    int    mx;
    int    mn;
    mx = 0;
    mn = 0;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        it  = q.pop_front();
        got = int'(offset_o);
        if (it.sym) begin
          checks++;
          if (mx != it.sym_p || mn != -it.sym_p) begin
            fails++;
            $display("FAIL R3 period extremes max=%0d min=%0d expected +/-%0d", mx, mn, it.sym_p);
          end
          mx = 0;
          mn = 0;
        end
        checks++;
        if (got != it.off || err_o !== it.err) begin
          fails++;
          $display("FAIL %s offset=%0d err=%0b expected offset=%0d err=%0b",
                   it.tag, got, err_o, it.off, it.err);
        end
        if (got > mx) mx = got;
        if (got < mn) mn = got;
      end
    end
  end

  // Stimulus
  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (offset_o !== '0 || err_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 in reset offset=%0d err=%0b expected offset=0 err=0", offset_o, err_o);
    end
    @(posedge clk);
    #2 rst_n = 1'b1;
    wait_cyc(500);
    apply(2'b01, 2'b01, 3'b011, "R2");
    wait_cyc(PERIOD); apply(2'b01, 2'b00, 3'b001, "R2");
    wait_cyc(PERIOD); apply(2'b10, 2'b00, 3'b010, "R2");
    wait_cyc(PERIOD); apply(2'b00, 2'b00, 3'b011, "R2");
    wait_cyc(PERIOD); apply(2'b00, 2'b01, 3'b000, "R2");
    wait_cyc(PERIOD); apply(2'b10, 2'b01, 3'b101, "R2");
    wait_cyc(PERIOD); apply(2'b01, 2'b10, 3'b110, "R2");
    wait_cyc(PERIOD); apply(2'b10, 2'b10, 3'b111, "R2");
    wait_cyc(PERIOD); apply(2'b00, 2'b10, 3'b100, "R2");
    wait_cyc(PERIOD); apply(2'b11, 2'b01, 3'b000, "R7");
    // enable drop in the middle of the low-high period
    wait_cyc(100);  spread_en = 1'b0;
    wait_cyc(120);  spread_en = 1'b1;
    wait_cyc(PERIOD - 220); apply(2'b10, 2'b01, 3'b010, "R8");
    wait_cyc(PERIOD); apply(2'b01, 2'b01, 3'b100, "R8");
    wait_cyc(PERIOD); apply(2'b00, 2'b00, 3'b000, "R4");
    wait_cyc(PERIOD + 700);
    if (!done) begin
      done = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired before the stimulus ended");
      summary();
      $finish;
    end
  end

endmodule